// File: doc/BRIEF.md
# PCI Configuration Access Translator

This block turns a single configuration request into word-aligned accesses on an external configuration window. A request carries a bus number, a device number, a function number, a register offset and a size of 1, 2 or 4 bytes. The block first checks the request. It then picks the window type, programs a window select register and issues one or two accesses on a simple memory-style master port. It returns one result word and an error code.

On bus 0 the target device is selected by a one-hot bit at position device+16. Bits of that select at or above `SPLIT_BIT` go into the window register, and the bits below it go into the address. On any other bus, the window register takes the type 1 code, and the address carries the bus and device numbers as binary fields. A 1- or 2-byte write is done as a read-modify-write of the containing word. A 4-byte write goes straight out. An abort from the memory port ends the request. When the single-slot card mode is set, only device 0 is reachable.

The controller is a state machine with six states:
- `ST_IDLE`: waits for a request.
- `ST_DECODE`: checks the latched request, then loads the address and window value.
- `ST_WIN`: pulses the window update.
- `ST_RD`: the read access.
- `ST_WR`: the write access.
- `ST_DONE`: the one-cycle completion pulse.

The transitions are:
- IDLE→DECODE on `req_valid`.
- DECODE→DONE on a rejected request; DECODE→WIN otherwise.
- WIN→WR for a 4-byte write; WIN→RD for everything else.
- RD→DONE on abort or on a read's acknowledge; RD→WR on a sub-word write's acknowledge.
- WR→DONE on acknowledge or abort.
- DONE→IDLE always.

Top module: `cfg_xlat`

## Requirements
- R1: A size other than 1, 2 or 4 ends with error code 1. It makes no memory access and no window update.
- R2: With `card_mode` high, any device number other than 0 ends with error code 2, with no access.
- R3: On bus 0, a device of `SLOT_MAX` (16) or above ends with error code 2. Otherwise the select bit 1<<(dev+16) is formed. Its bits at or above `SPLIT_BIT` (26) are ORed into the window value with type 0 code 0x2. Its lower bits are ORed into the address with `WIN_BASE`.
- R4: On a nonzero bus, the window value is the type 1 code 0x3. The address holds `WIN_BASE` ORed with bus at bits 23:16 and device at bits 15:11.
- R5: In both types, the function number sits at bits 10:8 and the offset has its low two bits cleared in the address.
- R6: The read result is the word shifted right by 8×offset[1:0], then zero-extended from the low 8, 16 or 32 bits per size.
- R7: A 1- or 2-byte write reads the word first. It replaces the byte lanes starting at 8×offset[1:0] with the new data, dropping any lanes above bit 31, and writes the merged word back to the same address.
- R8: A 4-byte write makes a single write access with the request data and no read.
- R9: An abort ends the request with error code 3. A read then returns 0xFFFFFFFF, and a write stores nothing.
- R10: `req_busy` is high from the cycle after acceptance up to and including the single-cycle `done` pulse, then falls.
- R11: The window update pulse occurs before the first memory access of every accepted request.
- R12: While `mem_req` waits for `mem_ack` or `mem_abort`, address, write-enable and write data stay unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| req_valid | input | 1 | Request strobe, taken only while not busy |
| req_write | input | 1 | 1 = write, 0 = read |
| req_bus | input | 8 | Bus number |
| req_dev | input | 5 | Device number |
| req_func | input | 3 | Function number |
| req_off | input | 8 | Register byte offset |
| req_size | input | 3 | Size in bytes |
| req_wdata | input | 32 | Write data, right-aligned |
| card_mode | input | 1 | Single-slot card mode |
| req_busy | output | 1 | Request in progress |
| done | output | 1 | One-cycle completion pulse |
| done_err | output | 2 | 0 ok, 1 bad size, 2 no device, 3 abort |
| done_rdata | output | 32 | Read result |
| win_upd | output | 1 | Pulse: window value just updated |
| win_val | output | 32 | Window select register |
| mem_req | output | 1 | Access request, held until response |
| mem_we | output | 1 | Access is a write |
| mem_addr | output | 32 | Word-aligned access address |
| mem_wdata | output | 32 | Write word |
| mem_ack | input | 1 | Access completed |
| mem_abort | input | 1 | Access aborted |
| mem_rdata | input | 32 | Read word, valid with `mem_ack` |

## Verification
The assertions rely on a few conditions:
- `mem_ack` and `mem_abort` are meaningful only while `mem_req` is high, and are single-cycle responses.
- `WIN_BASE` leaves bits `SPLIT_BIT`-1 down to 16 clear, so the one-hot count sees only the select bit.
- `req_valid` is raised only while `req_busy` is low.

The bench meets these conditions as follows:
- Its memory model answers only a pending access, after 0 to 2 wait cycles.
- It uses the default base.
- It issues each request only after the previous `done`.

Random requests cover both buses, device numbers beyond the slot limit, all offsets, legal and illegal sizes, card mode and injected aborts.

// File: rtl/cfg_xlat_pkg.sv
package cfg_xlat_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_DECODE,
        ST_WIN,
        ST_RD,
        ST_WR,
        ST_DONE
    } xl_state_t;

    typedef enum logic [1:0] {
        ERR_NONE  = 2'd0,
        ERR_SIZE  = 2'd1,
        ERR_NODEV = 2'd2,
        ERR_ABORT = 2'd3
    } xl_err_t;

    // function field position in the window address; the device and bus
    // fields of a type 1 address are stacked directly above it
    localparam int FN_LSB = 8;

endpackage

// File: rtl/cfg_xlat_addr.sv
module cfg_xlat_addr
    import cfg_xlat_pkg::*;
#(
    parameter int          AW        = 32,
    parameter int          BUS_W     = 8,
    parameter int          DEV_W     = 5,
    parameter int          FN_W      = 3,
    parameter int          OFF_W     = 8,
    parameter int          SLOT_MAX  = 16,
    parameter int          SPLIT_BIT = 26,
    parameter logic [31:0] WIN_BASE  = 32'h0C00_0000,
    parameter logic [31:0] CODE_T0   = 32'h0000_0002,
    parameter logic [31:0] CODE_T1   = 32'h0000_0003
) (
    input  logic [BUS_W-1:0] bus,
    input  logic [DEV_W-1:0] dev,
    input  logic [FN_W-1:0]  func,
    input  logic [OFF_W-1:0] off,
    input  logic             card,
    output logic [AW-1:0]    addr,
    output logic [AW-1:0]    win,
    output logic             bad_dev
);
    localparam int          DEV1_LSB = FN_LSB + FN_W;
    localparam int          BUS1_LSB = DEV1_LSB + DEV_W;
    localparam int          SEL_LSB  = BUS1_LSB;
    localparam logic [AW-1:0] HI_MASK = {AW{1'b1}} << SPLIT_BIT;
    localparam logic [AW-1:0] ONE     = AW'(1);

    logic [AW-1:0] sel;
    logic [AW-1:0] common;
    logic          type0;

    always_comb begin
        type0   = (bus == '0);
        sel     = ONE << (int'(dev) + SEL_LSB);
        common  = AW'(WIN_BASE) | (AW'(func) << FN_LSB) | (AW'(off) & ~AW'(3));
        bad_dev = (card && dev != '0) || (type0 && int'(dev) >= SLOT_MAX);
        if (type0) begin
            addr = common | (sel & ~HI_MASK);
            win  = AW'(CODE_T0) | (sel & HI_MASK);
        end else begin
            addr = common | (AW'(bus) << BUS1_LSB) | (AW'(dev) << DEV1_LSB);
            win  = AW'(CODE_T1);
        end
    end

endmodule

// File: rtl/cfg_xlat_lane.sv
module cfg_xlat_lane #(
    parameter int DW   = 32,
    parameter int SZ_W = 3
) (
    input  logic [DW-1:0]   word,
    input  logic [DW-1:0]   wdata,
    input  logic [1:0]      lane,
    input  logic [SZ_W-1:0] size,
    output logic [DW-1:0]   rd_val,
    output logic [DW-1:0]   merged
);
    logic [4:0]    sh;
    logic [DW-1:0] shifted;
    logic [DW-1:0] keep;
    logic [DW-1:0] ins;

    always_comb begin
        sh      = {lane, 3'b000};
        shifted = word >> sh;
        if (size == SZ_W'(1)) begin
            rd_val = DW'(shifted[7:0]);
            keep   = ~(DW'(8'hFF) << sh);
            ins    = DW'(wdata[7:0]) << sh;
        end else if (size == SZ_W'(2)) begin
            rd_val = DW'(shifted[15:0]);
            keep   = ~(DW'(16'hFFFF) << sh);
            ins    = DW'(wdata[15:0]) << sh;
        end else begin
            rd_val = shifted;
            keep   = '0;
            ins    = wdata;
        end
        merged = (word & keep) | ins;
    end

endmodule

// File: rtl/cfg_xlat_ctrl.sv
module cfg_xlat_ctrl
    import cfg_xlat_pkg::*;
#(
    parameter int AW        = 32,
    parameter int DW        = 32,
    parameter int BUS_W     = 8,
    parameter int DEV_W     = 5,
    parameter int FN_W      = 3,
    parameter int OFF_W     = 8,
    parameter int SZ_W      = 3,
    parameter int SPLIT_BIT = 26
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  logic             req_write,
    input  logic [BUS_W-1:0] req_bus,
    input  logic [DEV_W-1:0] req_dev,
    input  logic [FN_W-1:0]  req_func,
    input  logic [OFF_W-1:0] req_off,
    input  logic [SZ_W-1:0]  req_size,
    input  logic [DW-1:0]    req_wdata,
    input  logic             req_card,
    output logic [BUS_W-1:0] q_bus,
    output logic [DEV_W-1:0] q_dev,
    output logic [FN_W-1:0]  q_func,
    output logic [OFF_W-1:0] q_off,
    output logic [SZ_W-1:0]  q_size,
    output logic             q_card,
    output logic [DW-1:0]    q_wdata,
    input  logic [AW-1:0]    gen_addr,
    input  logic [AW-1:0]    gen_win,
    input  logic             gen_bad_dev,
    input  logic [DW-1:0]    lane_rdata,
    input  logic [DW-1:0]    lane_merged,
    output logic             req_busy,
    output logic             done,
    output logic [1:0]       done_err,
    output logic [DW-1:0]    done_rdata,
    output logic             win_upd,
    output logic [AW-1:0]    win_val,
    output logic             mem_req,
    output logic             mem_we,
    output logic [AW-1:0]    mem_addr,
    output logic [DW-1:0]    mem_wdata,
    input  logic             mem_ack,
    input  logic             mem_abort
);
    localparam int DEV1_LSB = FN_LSB + FN_W;
    localparam int BUS1_LSB = DEV1_LSB + DEV_W;
    localparam int SEL_LSB  = BUS1_LSB;

    xl_state_t     state_q, state_d;
    xl_err_t       err_q;
    logic          write_q;
    logic          size_ok;
    logic          full_wr;
    logic [DW-1:0] rdata_q;
    logic [AW-1:0] addr_q;
    logic          win_seen_q;
    logic          rd_ok_q;

    always_comb begin
        size_ok = (q_size == SZ_W'(1)) || (q_size == SZ_W'(2)) || (q_size == SZ_W'(4));
        full_wr = write_q && (q_size == SZ_W'(4));
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (req_valid) state_d = ST_DECODE;
            ST_DECODE: state_d = (!size_ok || gen_bad_dev) ? ST_DONE : ST_WIN;
            ST_WIN:    state_d = full_wr ? ST_WR : ST_RD;
            ST_RD: begin
                if (mem_abort)    state_d = ST_DONE;
                else if (mem_ack) state_d = write_q ? ST_WR : ST_DONE;
            end
            ST_WR:     if (mem_abort || mem_ack) state_d = ST_DONE;
            ST_DONE:   state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // request latch and data path
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q_bus      <= '0;
            q_dev      <= '0;
            q_func     <= '0;
            q_off      <= '0;
            q_size     <= '0;
            q_card     <= 1'b0;
            q_wdata    <= '0;
            write_q    <= 1'b0;
            err_q      <= ERR_NONE;
            rdata_q    <= '0;
            addr_q     <= '0;
            win_val    <= '0;
            win_seen_q <= 1'b0;
            rd_ok_q    <= 1'b0;
        end else begin
            unique case (state_q)
                ST_IDLE: if (req_valid) begin
                    q_bus      <= req_bus;
                    q_dev      <= req_dev;
                    q_func     <= req_func;
                    q_off      <= req_off;
                    q_size     <= req_size;
                    q_card     <= req_card;
                    q_wdata    <= req_wdata;
                    write_q    <= req_write;
                    err_q      <= ERR_NONE;
                    rdata_q    <= '0;
                    win_seen_q <= 1'b0;
                    rd_ok_q    <= 1'b0;
                end
                ST_DECODE: begin
                    if (!size_ok)         err_q <= ERR_SIZE;
                    else if (gen_bad_dev) err_q <= ERR_NODEV;
                    else begin
                        win_val <= gen_win;
                        addr_q  <= gen_addr;
                    end
                end
                ST_WIN: win_seen_q <= 1'b1;
                ST_RD: begin
                    if (mem_abort) begin
                        err_q   <= ERR_ABORT;
                        rdata_q <= '1;
                    end else if (mem_ack) begin
                        rd_ok_q <= 1'b1;
                        if (write_q) q_wdata <= lane_merged;
                        else         rdata_q <= lane_rdata;
                    end
                end
                ST_WR: if (mem_abort) err_q <= ERR_ABORT;
                ST_DONE: ;
                default: ;
            endcase
        end
    end

    // outputs
    always_comb begin
        req_busy   = (state_q != ST_IDLE);
        done       = (state_q == ST_DONE);
        win_upd    = (state_q == ST_WIN);
        mem_req    = (state_q == ST_RD) || (state_q == ST_WR);
        mem_we     = (state_q == ST_WR);
        mem_addr   = addr_q;
        mem_wdata  = q_wdata;
        done_err   = err_q;
        done_rdata = rdata_q;
    end

    assert_size_legal_R1: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> size_ok);

    assert_card_slot_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && q_card) |-> (q_dev == '0));

    // base address assumed clear between SPLIT_BIT-1 and SEL_LSB
    assert_onehot_split_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && q_bus == '0) |->
        ($countones({win_val[AW-1:SPLIT_BIT], mem_addr[SPLIT_BIT-1:SEL_LSB]}) == 1));

    assert_type1_fields_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && q_bus != '0) |->
        (mem_addr[BUS1_LSB +: BUS_W] == q_bus && mem_addr[DEV1_LSB +: DEV_W] == q_dev));

    assert_func_align_R5: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> (mem_addr[1:0] == 2'b00 && mem_addr[FN_LSB +: FN_W] == q_func));

    assert_rmw_read_first_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_we && q_size != SZ_W'(4)) |-> rd_ok_q);

    assert_full_no_read_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_we) |-> !full_wr);

    assert_abort_ends_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_abort) |=> (done && done_err == 2'd3));

    assert_abort_ones_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_we && !write_q && mem_abort) |=> (done_rdata == '1));

    assert_done_busy_R10: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> req_busy);

    assert_done_release_R10: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (!req_busy && !done));

    assert_win_first_R11: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> win_seen_q);

    assert_hold_access_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack && !mem_abort) |=>
        (mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata)));

endmodule

// File: rtl/cfg_xlat.sv
module cfg_xlat
    import cfg_xlat_pkg::*;
#(
    parameter int          AW        = 32,
    parameter int          DW        = 32,
    parameter int          BUS_W     = 8,
    parameter int          DEV_W     = 5,
    parameter int          FN_W      = 3,
    parameter int          OFF_W     = 8,
    parameter int          SZ_W      = 3,
    parameter int          SLOT_MAX  = 16,
    parameter int          SPLIT_BIT = 26,
    parameter logic [31:0] WIN_BASE  = 32'h0C00_0000,
    parameter logic [31:0] CODE_T0   = 32'h0000_0002,
    parameter logic [31:0] CODE_T1   = 32'h0000_0003
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  logic             req_write,
    input  logic [BUS_W-1:0] req_bus,
    input  logic [DEV_W-1:0] req_dev,
    input  logic [FN_W-1:0]  req_func,
    input  logic [OFF_W-1:0] req_off,
    input  logic [SZ_W-1:0]  req_size,
    input  logic [DW-1:0]    req_wdata,
    input  logic             card_mode,
    output logic             req_busy,
    output logic             done,
    output logic [1:0]       done_err,
    output logic [DW-1:0]    done_rdata,
    output logic             win_upd,
    output logic [AW-1:0]    win_val,
    output logic             mem_req,
    output logic             mem_we,
    output logic [AW-1:0]    mem_addr,
    output logic [DW-1:0]    mem_wdata,
    input  logic             mem_ack,
    input  logic             mem_abort,
    input  logic [DW-1:0]    mem_rdata
);
    logic [BUS_W-1:0] q_bus;
    logic [DEV_W-1:0] q_dev;
    logic [FN_W-1:0]  q_func;
    logic [OFF_W-1:0] q_off;
    logic [SZ_W-1:0]  q_size;
    logic             q_card;
    logic [DW-1:0]    q_wdata;
    logic [AW-1:0]    gen_addr;
    logic [AW-1:0]    gen_win;
    logic             gen_bad_dev;
    logic [DW-1:0]    lane_rdata;
    logic [DW-1:0]    lane_merged;

    cfg_xlat_addr #(
        .AW(AW), .BUS_W(BUS_W), .DEV_W(DEV_W), .FN_W(FN_W), .OFF_W(OFF_W),
        .SLOT_MAX(SLOT_MAX), .SPLIT_BIT(SPLIT_BIT), .WIN_BASE(WIN_BASE),
        .CODE_T0(CODE_T0), .CODE_T1(CODE_T1)
    ) u_addr (
        .bus(q_bus), .dev(q_dev), .func(q_func), .off(q_off), .card(q_card),
        .addr(gen_addr), .win(gen_win), .bad_dev(gen_bad_dev)
    );

    cfg_xlat_lane #(.DW(DW), .SZ_W(SZ_W)) u_lane (
        .word(mem_rdata), .wdata(q_wdata), .lane(q_off[1:0]), .size(q_size),
        .rd_val(lane_rdata), .merged(lane_merged)
    );

    cfg_xlat_ctrl #(
        .AW(AW), .DW(DW), .BUS_W(BUS_W), .DEV_W(DEV_W), .FN_W(FN_W),
        .OFF_W(OFF_W), .SZ_W(SZ_W), .SPLIT_BIT(SPLIT_BIT)
    ) u_ctrl (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_write(req_write), .req_bus(req_bus),
        .req_dev(req_dev), .req_func(req_func), .req_off(req_off),
        .req_size(req_size), .req_wdata(req_wdata), .req_card(card_mode),
        .q_bus(q_bus), .q_dev(q_dev), .q_func(q_func), .q_off(q_off),
        .q_size(q_size), .q_card(q_card), .q_wdata(q_wdata),
        .gen_addr(gen_addr), .gen_win(gen_win), .gen_bad_dev(gen_bad_dev),
        .lane_rdata(lane_rdata), .lane_merged(lane_merged),
        .req_busy(req_busy), .done(done), .done_err(done_err),
        .done_rdata(done_rdata), .win_upd(win_upd), .win_val(win_val),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_abort(mem_abort)
    );

endmodule

// File: tb/test_cfg_xlat.sv
module test_cfg_xlat;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [7:0]  req_bus = '0;
    logic [4:0]  req_dev = '0;
    logic [2:0]  req_func = '0;
    logic [7:0]  req_off = '0;
    logic [2:0]  req_size = '0;
    logic [31:0] req_wdata = '0;
    logic        card_mode = 1'b0;
    logic        req_busy, done, win_upd, mem_req, mem_we;
    logic [1:0]  done_err;
    logic [31:0] done_rdata, win_val, mem_addr, mem_wdata;
    logic        mem_ack = 1'b0;
    logic        mem_abort = 1'b0;
    logic [31:0] mem_rdata = '0;

    always #5 clk = ~clk;

    cfg_xlat i_cfg_xlat (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_bus(req_bus), .req_dev(req_dev), .req_func(req_func),
        .req_off(req_off), .req_size(req_size), .req_wdata(req_wdata),
        .card_mode(card_mode), .req_busy(req_busy), .done(done),
        .done_err(done_err), .done_rdata(done_rdata), .win_upd(win_upd),
        .win_val(win_val), .mem_req(mem_req), .mem_we(mem_we),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_ack(mem_ack),
        .mem_abort(mem_abort), .mem_rdata(mem_rdata)
    );

    int n_chk = 0;
    int n_bad = 0;

    // memory model and monitor state
    logic [31:0] store [logic [31:0]];
    int          n_rd, n_wr, n_abt, n_win, win_bad, addr_bad, order_bad, hold_bad;
    logic [31:0] exp_addr_g, exp_win_g, hold_addr;
    logic        abort_first = 1'b0;
    logic        acc_on = 1'b0;
    int          wait_left = 0;

    function automatic logic [31:0] dflt(input logic [31:0] a);
        return (a * 32'h9E37_79B1) ^ 32'h5A5A_5A5A;
    endfunction

    function automatic logic [31:0] mrd(input logic [31:0] a);
        if (store.exists(a)) return store[a];
        return dflt(a);
    endfunction

    task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] expv);
        n_chk++;
        if (act !== expv) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", rq, act, expv);
        end
    endtask

    always @(negedge clk) begin
        mem_ack   = 1'b0;
        mem_abort = 1'b0;
        if (rst_n) begin
            if (win_upd) n_win++;
            if (mem_req) begin
                if (!acc_on) begin
                    acc_on    = 1'b1;
                    hold_addr = mem_addr;
                    wait_left = $urandom % 3;
                    if (n_win != 1) order_bad++;
                    if (win_val != exp_win_g) win_bad++;
                    if (mem_addr != exp_addr_g) addr_bad++;
                end else if (mem_addr != hold_addr) begin
                    hold_bad++;
                end
                if (wait_left == 0) begin
                    acc_on = 1'b0;
                    if (abort_first) begin
                        abort_first = 1'b0;
                        mem_abort   = 1'b1;
                        n_abt++;
                    end else begin
                        mem_ack = 1'b1;
                        if (mem_we) begin
                            store[mem_addr] = mem_wdata;
                            n_wr++;
                        end else begin
                            mem_rdata = mrd(mem_addr);
                            n_rd++;
                        end
                    end
                end else begin
                    wait_left--;
                end
            end
        end
    end

    task automatic run_req(input logic wr, input logic [7:0] bus, input logic [4:0] dev,
                           input logic [2:0] fn, input logic [7:0] off, input logic [2:0] sz,
                           input logic [31:0] wd, input logic card, input logic abt);
        logic [31:0] sel, e_addr, e_win, pre, sh, e_rd, e_mem, msk;
        logic [1:0]  e_err;
        logic        bad_sz, bad_dv;
        int          t;
        string       tag;

        bad_sz = !(sz == 3'd1 || sz == 3'd2 || sz == 3'd4);
        bad_dv = (card && dev != 0) || (bus == 0 && dev >= 16);
        sel    = 32'h1 << (dev + 16);
        if (bus == 0) begin
            e_win  = 32'h2 | (sel & 32'hFC00_0000);
            e_addr = 32'h0C00_0000 | (sel & 32'h03FF_FFFF) | (32'(fn) << 8) | (32'(off) & 32'hFC);
        end else begin
            e_win  = 32'h3;
            e_addr = 32'h0C00_0000 | (32'(bus) << 16) | (32'(dev) << 11) | (32'(fn) << 8) | (32'(off) & 32'hFC);
        end
        e_err = bad_sz ? 2'd1 : (bad_dv ? 2'd2 : (abt ? 2'd3 : 2'd0));
        pre = mrd(e_addr);
        sh  = 32'(off[1:0]) * 8;
        e_rd = pre >> sh;
        if (sz == 3'd1) e_rd = e_rd & 32'hFF;
        if (sz == 3'd2) e_rd = e_rd & 32'hFFFF;
        msk = (sz == 3'd1) ? (32'hFF << sh) : (32'hFFFF << sh);
        e_mem = (sz == 3'd4) ? wd : ((pre & ~msk) | (((sz == 3'd1) ? (wd & 32'hFF) : (wd & 32'hFFFF)) << sh));

        tag = bad_sz ? "R1" : (bad_dv ? ((card && dev != 0) ? "R2" : "R3") : (abt ? "R9" : "R6"));

        n_rd = 0; n_wr = 0; n_abt = 0; n_win = 0;
        win_bad = 0; addr_bad = 0; order_bad = 0; hold_bad = 0;
        exp_addr_g = e_addr; exp_win_g = e_win; abort_first = abt;

        @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_bus = bus; req_dev = dev;
        req_func = fn; req_off = off; req_size = sz; req_wdata = wd; card_mode = card;
        @(negedge clk);
        req_valid = 1'b0;
        chk("R10 busy after accept", 32'(req_busy), 32'h1);
        t = 0;
        while (!done && t < 100) begin
            @(negedge clk);
            t++;
        end
        chk("R10 done seen", 32'(done), 32'h1);
        chk({tag, " error code"}, 32'(done_err), 32'(e_err));
        if (bad_sz || bad_dv) begin
            chk({tag, " no access"}, 32'(n_rd + n_wr + n_abt + n_win), 32'h0);
        end else begin
            chk((bus == 0) ? "R3 window value" : "R4 window value", 32'(win_bad), 32'h0);
            chk((bus == 0) ? "R3 R5 address" : "R4 R5 address", 32'(addr_bad), 32'h0);
            chk("R11 window before access", 32'(order_bad), 32'h0);
            chk("R12 address held", 32'(hold_bad), 32'h0);
            if (!wr) begin
                chk(abt ? "R9 read all ones" : "R6 read data", done_rdata, abt ? 32'hFFFF_FFFF : e_rd);
            end else if (abt) begin
                chk("R9 write abandoned", 32'(n_wr), 32'h0);
                chk("R9 memory kept", mrd(e_addr), pre);
            end else if (sz == 3'd4) begin
                chk("R8 accesses", 32'(n_rd * 16 + n_wr), 32'h1);
                chk("R8 memory word", mrd(e_addr), e_mem);
            end else begin
                chk("R7 accesses", 32'(n_rd * 16 + n_wr), 32'h11);
                chk("R7 merged word", mrd(e_addr), e_mem);
            end
        end
        @(negedge clk);
        chk("R10 released", 32'({req_busy, done}), 32'h0);
    endtask

    initial begin
        #1_000_000;
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd2718));
        repeat (3) @(negedge clk);
        chk("reset busy", 32'(req_busy), 32'h0);
        chk("reset done", 32'(done), 32'h0);
        chk("reset mem_req", 32'(mem_req), 32'h0);
        chk("reset window", win_val, 32'h0);
        rst_n = 1'b1;
        @(negedge clk);

        // directed corners
        run_req(1'b0, 8'd0, 5'd3, 3'd1, 8'h10, 3'd3, 32'h0, 1'b0, 1'b0);   // R1 size 3
        run_req(1'b1, 8'd0, 5'd2, 3'd0, 8'h04, 3'd0, 32'h1, 1'b0, 1'b0);   // R1 size 0
        run_req(1'b0, 8'd0, 5'd1, 3'd0, 8'h00, 3'd4, 32'h0, 1'b1, 1'b0);   // R2
        run_req(1'b0, 8'd5, 5'd0, 3'd2, 8'h08, 3'd4, 32'h0, 1'b1, 1'b0);   // R2 dev 0 allowed
        run_req(1'b0, 8'd0, 5'd16, 3'd0, 8'h00, 3'd4, 32'h0, 1'b0, 1'b0);  // R3 limit
        run_req(1'b0, 8'd0, 5'd15, 3'd7, 8'hFF, 3'd1, 32'h0, 1'b0, 1'b0);  // R3 high split
        run_req(1'b0, 8'd0, 5'd9, 3'd3, 8'h3D, 3'd2, 32'h0, 1'b0, 1'b0);   // R3 low split
        run_req(1'b0, 8'd0, 5'd10, 3'd0, 8'h02, 3'd2, 32'h0, 1'b0, 1'b0);  // R3 first high bit
        run_req(1'b0, 8'hFF, 5'd31, 3'd7, 8'hFE, 3'd2, 32'h0, 1'b0, 1'b0); // R4 R5 extremes
        run_req(1'b1, 8'd0, 5'd4, 3'd1, 8'h23, 3'd1, 32'hAB, 1'b0, 1'b0);  // R7 byte 3
        run_req(1'b1, 8'd0, 5'd4, 3'd1, 8'h23, 3'd2, 32'hCDEF, 1'b0, 1'b0);// R7 upper lane drops
        run_req(1'b1, 8'd7, 5'd1, 3'd1, 8'h21, 3'd2, 32'h1234, 1'b0, 1'b0);// R7 middle lanes
        run_req(1'b1, 8'd7, 5'd1, 3'd1, 8'h20, 3'd4, 32'hDEAD_BEEF, 1'b0, 1'b0); // R8
        run_req(1'b0, 8'd7, 5'd1, 3'd1, 8'h20, 3'd4, 32'h0, 1'b0, 1'b1);   // R9 read abort
        run_req(1'b1, 8'd0, 5'd6, 3'd0, 8'h41, 3'd1, 32'h77, 1'b0, 1'b1);  // R9 rmw abort
        run_req(1'b1, 8'd2, 5'd6, 3'd0, 8'h40, 3'd4, 32'h55, 1'b0, 1'b1);  // R9 full write abort

        // constrained random
        for (int k = 0; k < 400; k++) begin
            logic [7:0]  rb;
            logic [2:0]  rs;
            int          r;
            rb = ($urandom % 2 == 0) ? 8'd0 : 8'(1 + $urandom % 255);
            r  = $urandom % 10;
            if (r == 0)      rs = 3'(($urandom % 2 == 0) ? 3 : 5 + $urandom % 3);
            else if (r < 4)  rs = 3'd1;
            else if (r < 7)  rs = 3'd2;
            else             rs = 3'd4;
            run_req(1'($urandom % 2), rb, 5'($urandom % 20), 3'($urandom % 8),
                    8'($urandom % 256), rs, $urandom, ($urandom % 10 == 0),
                    ($urandom % 10 == 0));
        end

        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

endmodule